// File: doc/BRIEF.md
# Root Port System-Error and Power-Event Signaling

This block holds the root-port control word and turns incoming error reports and power-management event messages into two alerts for the host. The first is a system-error pulse, `serr_pulse`. The second is a level-sensitive power-event interrupt, `pme_irq`. Software programs the control word through a small configuration read/write port at offset 0xBC. The low four bits of that word are writable. Bits 2:0 are per-class system-error enables and bit 3 is the power-event interrupt enable.

Error reports arrive as single-cycle strobes on two 3-bit vectors. `err_dev` carries reports from devices below the port and `err_self` carries reports the port raises itself. On both vectors, bit 0 is a correctable error, bit 1 is a non-fatal uncorrectable error and bit 2 is a fatal error.

An enabled class raises the system error whatever the generic command-register enable says. A class whose bit is clear falls back to the command-register enable input, `cmd_serr_en`.

A power-event message strobe sets a sticky status flag. Software clears that flag by writing one to it through a separate status-write port. The interrupt follows the flag gated by the enable. Turning the enable on while the flag is already set therefore raises the interrupt straight away.

Top module: `rp_alert_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, and `pme_status`, `pme_irq` and `serr_pulse` are all 0.
- R2: A write with `cfg_addr` = 0xBC updates control bits 3:0 on the next clock edge. A read at 0xBC returns the control word combinationally. Reads at any other address return 0, and writes there leave the control word unchanged.
- R3: Bits 15:4 of the control word always read as 0, whatever value was written.
- R4: When control bit 0 is set, a correctable strobe (bit 0 of `err_dev` or `err_self`) produces a system error even with `cmd_serr_en` low. When bit 0 is clear and `cmd_serr_en` is low, it produces none.
- R5: The same rule holds for non-fatal strobes (vector bit 1), enabled by control bit 1.
- R6: The same rule holds for fatal strobes (vector bit 2), enabled by control bit 2.
- R7: For a strobe whose class enable is clear, a system error is produced exactly when `cmd_serr_en` is 1 in the strobe's cycle.
- R8: `serr_pulse` is high for exactly the one cycle after a cycle with at least one qualifying strobe. Several qualifying strobes in one cycle give one pulse. `serr_pulse` is never high without a strobe in the previous cycle.
- R9: A `pme_msg` strobe sets `pme_status` on the next edge. A status write with `sts_wr_en`=1 and `sts_pme_w1c`=1 clears it, while `sts_pme_w1c`=0 leaves it alone. If a message and a clear arrive in the same cycle, the message wins.
- R10: `pme_irq` is high exactly when `pme_status` is 1 and control bit 3 is 1. With bit 3 clear, a message sets the status but does not raise the interrupt.
- R11: Writing control bit 3 from 0 to 1 while `pme_status` is already 1 raises `pme_irq` in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data (combinational) |
| cmd_serr_en | input | 1 | Generic command-register system-error enable |
| err_dev | input | 3 | Error strobes from downstream devices (bit0 correctable, bit1 non-fatal, bit2 fatal) |
| err_self | input | 3 | Error strobes raised by the port itself, same encoding |
| pme_msg | input | 1 | Power-event message received strobe |
| sts_wr_en | input | 1 | Status write strobe |
| sts_pme_w1c | input | 1 | Write-one-to-clear data for the power-event status flag |
| serr_pulse | output | 1 | One-cycle system-error pulse |
| pme_status | output | 1 | Sticky power-event status flag |
| pme_irq | output | 1 | Level power-event interrupt |

## Verification
The properties assume that the error vectors, `pme_msg` and the status-write inputs are driven low during reset. They also assume these inputs are settled at every rising edge, because each property compares a registered output with the previous cycle's inputs. The stimulus changes every input only on the falling clock edge and holds all strobes at zero through reset. A strobe is raised for exactly one cycle and then returned to zero before the next case starts. This keeps each system-error pulse attributable to a single stimulus cycle.

// File: rtl/rp_alert_pkg.sv
package rp_alert_pkg;

    localparam int unsigned NUM_CLASS  = 3;
    localparam int unsigned PME_IE_BIT = NUM_CLASS;

    typedef enum int unsigned {
        CLS_CORR     = 0,
        CLS_NONFATAL = 1,
        CLS_FATAL    = 2
    } err_class_e;

    typedef struct packed {
        logic                 pme_ie;
        logic [NUM_CLASS-1:0] cls_en;
    } ctrl_fields_t;

    localparam int unsigned CTRL_FIELD_W = $bits(ctrl_fields_t);

endpackage

// File: rtl/rp_ctrl_reg.sv
module rp_ctrl_reg
    import rp_alert_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 16,
    parameter logic [ADDR_W-1:0] OFFSET = 'hBC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_fields_t      fields
);

    localparam int unsigned PAD_W = DATA_W - CTRL_FIELD_W;

    typedef struct packed {
        ctrl_fields_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit;

    assign hit = (addr == OFFSET);

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.ctrl = ctrl_fields_t'(wdata[CTRL_FIELD_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Reserved upper bits are never stored, so they always read zero.
    assign rdata  = hit ? {{PAD_W{1'b0}}, st_q.ctrl} : '0;
    assign fields = st_q.ctrl;

endmodule

// File: rtl/rp_serr_gen.sv
module rp_serr_gen
    import rp_alert_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CLASS-1:0] err_dev,
    input  logic [NUM_CLASS-1:0] err_self,
    input  logic [NUM_CLASS-1:0] cls_en,
    input  logic                 cmd_serr_en,
    output logic                 serr
);

    typedef struct packed {
        logic serr;
    } serr_state_t;

    serr_state_t          st_d, st_q;
    logic [NUM_CLASS-1:0] cls_hit;

    // One qualifier per error class: the class enable overrides the generic enable.
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        logic seen;
        assign seen       = err_dev[c] | err_self[c];
        assign cls_hit[c] = seen & (cls_en[c] | cmd_serr_en);
    end

    always_comb begin
        st_d      = st_q;
        st_d.serr = |cls_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign serr = st_q.serr;

endmodule

// File: rtl/rp_pme_track.sv
module rp_pme_track (
    input  logic clk,
    input  logic rst_n,
    input  logic msg,
    input  logic clr,
    input  logic irq_en,
    output logic status,
    output logic irq
);

    typedef struct packed {
        logic status;
    } pme_state_t;

    pme_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (msg) begin
            st_d.status = 1'b1;
        end else if (clr) begin
            st_d.status = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
    // Level output: enabling with status already set raises it immediately.
    assign irq    = st_q.status & irq_en;

endmodule

// File: rtl/rp_alert_ctrl.sv
module rp_alert_ctrl
    import rp_alert_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'hBC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              cmd_serr_en,
    input  logic [2:0]        err_dev,
    input  logic [2:0]        err_self,
    input  logic              pme_msg,
    input  logic              sts_wr_en,
    input  logic              sts_pme_w1c,
    output logic              serr_pulse,
    output logic              pme_status,
    output logic              pme_irq
);

    ctrl_fields_t               fields;
    logic [CTRL_FIELD_W-1:0]    ctrl_bits;
    logic                       pme_clr;

    assign ctrl_bits = fields;
    assign pme_clr   = sts_wr_en & sts_pme_w1c;

    rp_ctrl_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFFSET (CTRL_OFFSET)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .fields (fields)
    );

    rp_serr_gen u_serr (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_dev     (err_dev),
        .err_self    (err_self),
        .cls_en      (fields.cls_en),
        .cmd_serr_en (cmd_serr_en),
        .serr        (serr_pulse)
    );

    rp_pme_track u_pme (
        .clk    (clk),
        .rst_n  (rst_n),
        .msg    (pme_msg),
        .clr    (pme_clr),
        .irq_en (fields.pme_ie),
        .status (pme_status),
        .irq    (pme_irq)
    );

endmodule

// File: rtl/rp_alert_ctrl_chk.sv
module rp_alert_ctrl_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        ctrl_bits,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              cmd_serr_en,
    input logic [2:0]        err_dev,
    input logic [2:0]        err_self,
    input logic              pme_msg,
    input logic              sts_wr_en,
    input logic              sts_pme_w1c,
    input logic              serr_pulse,
    input logic              pme_status,
    input logic              pme_irq
);

    // R3: upper bits never read back as one
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:4] == '0);

    // R4 R5 R6: an enabled class always yields a pulse
    p_class_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|((err_dev | err_self) & ctrl_bits[2:0])) |=> serr_pulse);

    // R7: generic enable covers any class
    p_cmd_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_serr_en && |(err_dev | err_self)) |=> serr_pulse);

    // R8: no pulse without a strobe one cycle earlier
    p_serr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> $past(|(err_dev | err_self)));

    // R9: message sets status
    p_pme_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pme_msg |=> pme_status);

    // R9: clear without message drops status
    p_pme_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_en && sts_pme_w1c && !pme_msg) |=> !pme_status);

    // R10: interrupt needs both status and enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq |-> (pme_status && ctrl_bits[3]));

    // R11: enable rising with status held raises the interrupt
    p_irq_on_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_bits[3]) && pme_status) |-> pme_irq);

endmodule

bind rp_alert_ctrl rp_alert_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_bits   (ctrl_bits),
    .cfg_rdata   (cfg_rdata),
    .cmd_serr_en (cmd_serr_en),
    .err_dev     (err_dev),
    .err_self    (err_self),
    .pme_msg     (pme_msg),
    .sts_wr_en   (sts_wr_en),
    .sts_pme_w1c (sts_pme_w1c),
    .serr_pulse  (serr_pulse),
    .pme_status  (pme_status),
    .pme_irq     (pme_irq)
);

// File: tb/rp_alert_ctrl_bench.sv
module rp_alert_ctrl_bench;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 16;
    localparam logic [ADDR_W-1:0] OFF = 12'hBC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = OFF;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic              cmd_serr_en = 1'b0;
    logic [2:0]        err_dev = '0;
    logic [2:0]        err_self = '0;
    logic              pme_msg = 1'b0;
    logic              sts_wr_en = 1'b0;
    logic              sts_pme_w1c = 1'b0;
    logic              serr_pulse;
    logic              pme_status;
    logic              pme_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;  // 50 MHz

    rp_alert_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFSET(OFF)) u_rp_alert_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_serr_en(cmd_serr_en),
        .err_dev(err_dev), .err_self(err_self), .pme_msg(pme_msg),
        .sts_wr_en(sts_wr_en), .sts_pme_w1c(sts_pme_w1c), .serr_pulse(serr_pulse),
        .pme_status(pme_status), .pme_irq(pme_irq)
    );

    // Vector: {cls_en[2:0], cmd, dev[2:0], self[2:0], expected serr}
    localparam int NVEC = 12;
    localparam logic [10:0] VEC [NVEC] = '{
        {3'b001, 1'b0, 3'b001, 3'b000, 1'b1},  // R4 downstream
        {3'b001, 1'b0, 3'b000, 3'b001, 1'b1},  // R4 self
        {3'b010, 1'b0, 3'b010, 3'b000, 1'b1},  // R5
        {3'b100, 1'b0, 3'b000, 3'b100, 1'b1},  // R6
        {3'b000, 1'b0, 3'b111, 3'b111, 1'b0},  // R7 all off
        {3'b000, 1'b1, 3'b100, 3'b000, 1'b1},  // R7 generic enable
        {3'b110, 1'b0, 3'b001, 3'b000, 1'b0},  // R4 class off
        {3'b011, 1'b0, 3'b100, 3'b000, 1'b0},  // R6 class off
        {3'b111, 1'b0, 3'b111, 3'b111, 1'b1},  // R8 many strobes
        {3'b101, 1'b0, 3'b010, 3'b010, 1'b0},  // R5 class off
        {3'b000, 1'b1, 3'b000, 3'b010, 1'b1},  // R7 self
        {3'b111, 1'b1, 3'b000, 3'b000, 1'b0}   // R8 no strobe
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr_en = 1'b1;
        tick();
        cfg_wr_en = 1'b0;
        cfg_addr  = OFF;
    endtask

    task automatic serr_case(input logic [2:0] en, input logic cmd, input logic [2:0] dv,
                             input logic [2:0] sf, input logic exp, input string tag);
        cfg_write(OFF, {13'b0, en});
        cmd_serr_en = cmd;
        err_dev     = dv;
        err_self    = sf;
        tick();
        err_dev  = '0;
        err_self = '0;
        check(tag, serr_pulse, exp);
        tick();
        check({tag, " R8 pulse ends"}, serr_pulse, 1'b0);
        cmd_serr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1;
        check("R1 ctrl", cfg_rdata, 16'h0000);
        check("R1 status", pme_status, 1'b0);
        check("R1 irq", pme_irq, 1'b0);
        check("R1 serr", serr_pulse, 1'b0);

        // R2 R3 register access
        cfg_write(OFF, 16'hFFFF);
        #1 check("R3 reserved read zero", cfg_rdata, 16'h000F);
        cfg_addr = 12'hB8;
        #1 check("R2 other addr reads zero", cfg_rdata, 16'h0000);
        cfg_write(12'hB8, 16'h0000);
        #1 check("R2 other addr write ignored", cfg_rdata, 16'h000F);
        cfg_write(OFF, 16'hA5A5);
        #1 check("R2 R3 write 5", cfg_rdata, 16'h0005);
        cfg_write(OFF, 16'h0000);

        // Table of SERR vectors
        for (int i = 0; i < NVEC; i++) begin
            serr_case(VEC[i][10:8], VEC[i][7], VEC[i][6:4], VEC[i][3:1], VEC[i][0],
                      $sformatf("R4/R5/R6/R7 table row %0d", i));
        end

        // Exhaustive class x enable x source
        for (int en = 0; en < 8; en++) begin
            for (int cmd = 0; cmd < 2; cmd++) begin
                for (int c = 0; c < 3; c++) begin
                    for (int src = 0; src < 2; src++) begin
                        logic [2:0] strobe;
                        logic       exp;
                        strobe = 3'(1 << c);
                        exp    = en[c] | cmd[0];
                        serr_case(en[2:0], cmd[0], src == 0 ? strobe : 3'b000,
                                  src == 1 ? strobe : 3'b000, exp,
                                  $sformatf("R4/R5/R6/R7 sweep en=%0d cmd=%0d cls=%0d src=%0d",
                                            en, cmd, c, src));
                    end
                end
            end
        end

        // R9 R10 R11 power events
        cfg_write(OFF, 16'h0000);
        pme_msg = 1'b1;
        tick();
        pme_msg = 1'b0;
        check("R9 message sets status", pme_status, 1'b1);
        check("R10 no irq while disabled", pme_irq, 1'b0);
        cfg_write(OFF, 16'h0008);
        check("R11 irq on enable with status set", pme_irq, 1'b1);
        sts_wr_en = 1'b1;
        sts_pme_w1c = 1'b0;
        tick();
        sts_wr_en = 1'b0;
        check("R9 write zero keeps status", pme_status, 1'b1);
        sts_wr_en = 1'b1;
        sts_pme_w1c = 1'b1;
        tick();
        sts_wr_en = 1'b0;
        sts_pme_w1c = 1'b0;
        check("R9 write one clears status", pme_status, 1'b0);
        check("R10 irq drops with status", pme_irq, 1'b0);
        pme_msg = 1'b1;
        tick();
        pme_msg = 1'b0;
        check("R10 irq on message when enabled", pme_irq, 1'b1);
        cfg_write(OFF, 16'h0000);
        check("R10 irq drops with enable", pme_irq, 1'b0);
        check("R10 status held after disable", pme_status, 1'b1);
        pme_msg = 1'b1;
        sts_wr_en = 1'b1;
        sts_pme_w1c = 1'b1;
        tick();
        pme_msg = 1'b0;
        sts_wr_en = 1'b0;
        sts_pme_w1c = 1'b0;
        check("R9 message wins over clear", pme_status, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule